// File: doc/BRIEF.md
# Serial Converter Port Controller

This block is the digital side of a two-channel 12-bit successive-approximation converter that talks to a host over a half-duplex synchronous serial link. The host pulls chip select low, clocks in a start bit followed by a four-bit setup word, then reads the result back on the same clock. The setup word chooses the input pairing, the order in which result bits are sent, and whether the converter should shut down instead of converting.

The analog core is replaced by a parallel result input, which the block captures at the moment the sample phase closes. The block drives the channel-select lines for the input multiplexer and a flag that marks the sample window. It also drives the serial output together with its enable, so that a pad can turn it into a three-state pin. Raising chip select at any point abandons the exchange and returns the block to idle.

Top module: `adc_serial_ctrl`

## Requirements
- R1: While chip select is high, dout_oe, sampling, pos_sel, neg_sel and neg_gnd are all low.
- R2: After chip select falls, zeros sampled on din at rising sclk edges are skipped. The first one sampled is the start bit.
- R3: The four rising edges after the start bit capture, in this order, sgl (1 = single-ended), odd, msbf (1 = MSB-first only) and ps (0 = shutdown request). din is ignored after that. dout_oe rises on the falling edge after the ps edge and stays high until chip select rises.
- R4: Once odd is captured, pos_sel is {odd, ~odd} (bit 0 = CH0, bit 1 = CH1 as the plus input). With sgl=1, neg_gnd=1 and neg_sel=0. With sgl=0, neg_gnd=0 and neg_sel is {~odd, odd}. Before that point all three are zero.
- R5: sampling rises on the rising edge that captures odd and falls on the falling edge that follows the ps edge, which makes it 2.5 clocks wide.
- R6: On the falling edge that enables the output, a null 0 is driven and conv_data is latched. The next twelve falling edges present B11 down to B0 of that latched value. Later changes on conv_data have no effect.
- R7: With msbf=1, dout is 0 after B0 for as long as chip select stays low.
- R8: With msbf=0, B1 through B11 follow B0, one per falling edge, and dout is 0 after that.
- R9: With ps=0, twelve ones follow the null bit and zeros come after them. pwr_down goes high on the ps edge and stays high through the rest of the exchange and the idle time after it. It clears on the first rising sclk edge of the next exchange.
- R10: Raising chip select in the middle of an exchange aborts it. The next exchange then runs normally from its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low power-on reset for the shutdown flag |
| cs_n | input | 1 | Active-low chip select; high resets the exchange |
| sclk | input | 1 | Serial shift clock |
| din | input | 1 | Serial data from the host |
| conv_data | input | DATA_W | Parallel result from the converter core |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Output enable for dout (low = high impedance) |
| sampling | output | 1 | High during the sample window |
| pwr_down | output | 1 | Latched shutdown request |
| pos_sel | output | 2 | Plus-input select, bit 0 = CH0, bit 1 = CH1 |
| neg_sel | output | 2 | Minus-input select, bit 0 = CH0, bit 1 = CH1 |
| neg_gnd | output | 1 | Minus input tied to ground (single-ended) |

## Verification
The assertions check several properties on every clock while chip select is low. The plus and minus selections never name the same channel, and the selection holds steady once it is decoded. The output enable never drops mid-exchange and never overlaps the sample window. The sample window is exactly as wide as required, and a shutdown request is only latched at the end of a sample window. Several behaviours can only be shown by the bench's scenarios, against a reference that rebuilds the expected bit stream: which value each serial bit carries, skipping of leading zeros, both bit orders with their zero fill, the all-ones shutdown word, capture of the result at the hold instant, and recovery after an abort.

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl #(
  parameter int DATA_W = 12
) (
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] conv_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              sampling,
  output logic              pwr_down,
  output logic [1:0]        pos_sel,
  output logic [1:0]        neg_sel,
  output logic              neg_gnd
);
  localparam int CFG_N    = 4;
  localparam int LAST_MSB = CFG_N + DATA_W;
  localparam int LAST_LSB = CFG_N + 2 * DATA_W - 1;
  localparam int SAT      = LAST_LSB + 1;
  localparam int CW       = $clog2(SAT + 1);
  localparam int IW       = $clog2(DATA_W);

  localparam logic [CW-1:0] C_ODD   = CW'(2);
  localparam logic [CW-1:0] C_PS    = CW'(3);
  localparam logic [CW-1:0] C_CFG   = CW'(CFG_N);
  localparam logic [CW-1:0] C_FIRST = CW'(CFG_N + 1);
  localparam logic [CW-1:0] C_LMSB  = CW'(LAST_MSB);
  localparam logic [CW-1:0] C_LLSB  = CW'(LAST_LSB);
  localparam logic [CW-1:0] C_SAT   = CW'(SAT);

  logic              started;
  logic [CW-1:0]     cnt;
  logic              sgl_q, odd_q, msbf_q, ps_q;
  logic              oe_q, dout_q, hold_q, pd_q;
  logic [DATA_W-1:0] res_q;
  logic              bit_nx;

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      started <= 1'b0;
      cnt     <= '0;
      sgl_q   <= 1'b0;
      odd_q   <= 1'b0;
      msbf_q  <= 1'b0;
      ps_q    <= 1'b0;
    end else if (!started) begin
      started <= din;
    end else if (cnt < C_CFG) begin
      case (cnt)
        CW'(0):  sgl_q  <= din;
        CW'(1):  odd_q  <= din;
        C_ODD:   msbf_q <= din;
        default: ps_q   <= din;
      endcase
      cnt <= cnt + CW'(1);
    end else if (cnt < C_SAT) begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)
      pd_q <= 1'b0;
    else if (!cs_n) begin
      if (!started)
        pd_q <= 1'b0;
      else if (cnt == C_PS)
        pd_q <= ~din;
    end
  end

  always_comb begin
    bit_nx = 1'b0;
    if (cnt >= C_FIRST && cnt <= C_LMSB)
      bit_nx = ps_q ? res_q[IW'(C_LMSB - cnt)] : 1'b1;
    else if (cnt > C_LMSB && cnt <= C_LLSB)
      bit_nx = ps_q & ~msbf_q & res_q[IW'(cnt - C_LMSB)];
  end

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      oe_q   <= 1'b0;
      dout_q <= 1'b0;
      hold_q <= 1'b0;
      res_q  <= '0;
    end else if (started && cnt >= C_CFG) begin
      oe_q   <= 1'b1;
      dout_q <= bit_nx;
      if (cnt == C_CFG) begin
        hold_q <= 1'b1;
        res_q  <= conv_data;
      end
    end
  end

  wire mux_ok = started && cnt >= C_ODD;

  assign dout     = dout_q;
  assign dout_oe  = oe_q;
  assign sampling = mux_ok && !hold_q;
  assign pwr_down = pd_q;
  assign pos_sel  = mux_ok ? {odd_q, ~odd_q} : 2'b00;
  assign neg_sel  = (mux_ok && !sgl_q) ? {~odd_q, odd_q} : 2'b00;
  assign neg_gnd  = mux_ok && sgl_q;
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk #(
  parameter int DATA_W = 12
) (
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              din,
  input logic [DATA_W-1:0] conv_data,
  input logic              dout,
  input logic              dout_oe,
  input logic              sampling,
  input logic              pwr_down,
  input logic [1:0]        pos_sel,
  input logic [1:0]        neg_sel,
  input logic              neg_gnd
);
  AST_SEL_DISJOINT: assert property (@(posedge sclk) disable iff (cs_n)
    ((pos_sel & neg_sel) == 2'b00) && !(neg_gnd && neg_sel != 2'b00)); // R4

  AST_SEL_HELD: assert property (@(posedge sclk) disable iff (cs_n)
    (pos_sel != 2'b00) |=> $stable(pos_sel) && $stable(neg_sel) && $stable(neg_gnd)); // R4

  AST_OE_HELD: assert property (@(posedge sclk) disable iff (cs_n)
    dout_oe |=> dout_oe); // R3

  AST_SAMPLE_VS_DRIVE: assert property (@(posedge sclk) disable iff (cs_n)
    sampling |-> !dout_oe); // R5

  AST_SAMPLE_WIDTH: assert property (@(posedge sclk) disable iff (cs_n)
    $fell(sampling) |-> $past(sampling, 2) && !$past(sampling, 3)); // R5

  AST_PD_AFTER_SAMPLE: assert property (@(posedge sclk) disable iff (cs_n || !rst_n)
    $rose(pwr_down) |-> $past(sampling)); // R9
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_adc_serial_ctrl.sv
module test_adc_serial_ctrl;
  logic        rst_n = 1'b0;
  logic        cs_n  = 1'b1;
  logic        sclk  = 1'b0;
  logic        din   = 1'b0;
  logic [11:0] conv_data = '0;
  logic        dout, dout_oe, sampling, pwr_down, neg_gnd;
  logic [1:0]  pos_sel, neg_sel;

  int total = 0;
  int bad   = 0;
  bit pd_prev = 1'b0;

  adc_serial_ctrl i_adc_serial_ctrl (.*);

  always #4 sclk = ~sclk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check();
    chk("R1 oe idle", dout_oe, 0);
    chk("R1 sampling idle", sampling, 0);
    chk("R1 pos_sel idle", pos_sel, 0);
    chk("R1 neg_sel idle", neg_sel, 0);
    chk("R1 neg_gnd idle", neg_gnd, 0);
    chk("R9 pwr_down held idle", pwr_down, pd_prev);
  endtask

  task automatic txn(int z, bit sgl, bit odd, bit msbf, bit ps, logic [11:0] val, int nclk);
    int s = z;
    bit [3:0] cfg = {sgl, odd, msbf, ps};
    conv_data = val;
    for (int j = 0; j < nclk; j++) begin
      @(negedge sclk); #1;
      if (j == 0) cs_n = 1'b0;
      if (j < s)           din = 1'b0;
      else if (j == s)     din = 1'b1;
      else if (j <= s + 4) din = cfg[3 - (j - s - 1)];
      else                 din = j[0];
      if (j == s + 6) conv_data = ~val;
      #2;
      begin
        bit eoe = (j >= s + 5);
        int m = j - (s + 5);
        bit ebit = 1'b0;
        string tag = "R6";
        chk("R3 dout_oe", dout_oe, eoe);
        if (eoe) begin
          if (m == 0) ebit = 1'b0;
          else if (m <= 12) begin
            if (ps) ebit = val[12 - m];
            else begin ebit = 1'b1; tag = "R9"; end
          end else if (!ps) begin ebit = 1'b0; tag = "R9"; end
          else if (msbf) begin ebit = 1'b0; tag = "R7"; end
          else begin tag = "R8"; ebit = (m <= 23) ? val[m - 12] : 1'b0; end
          chk({tag, " dout"}, dout, ebit);
        end else if (j <= s) begin
          chk("R2 no output before start", dout_oe, 0);
        end
        if (j >= s + 3) begin
          chk("R4 pos_sel", pos_sel, {odd, ~odd});
          chk("R4 neg_sel", neg_sel, sgl ? 2'b00 : {~odd, odd});
          chk("R4 neg_gnd", neg_gnd, sgl);
        end else begin
          chk("R4 pos_sel undecoded", pos_sel, 0);
          chk("R4 neg_gnd undecoded", neg_gnd, 0);
        end
        chk("R5 sampling before edge", sampling, (j >= s + 3 && j <= s + 4));
        if (j == 0) chk("R9 pwr_down carry", pwr_down, pd_prev);
        else chk("R9 pwr_down", pwr_down, (j >= s + 5) && !ps);
      end
      @(posedge sclk); #1;
      chk("R5 sampling after edge", sampling, (j >= s + 2 && j <= s + 4));
    end
    pd_prev = (!ps && (nclk - 1 >= s + 4));
    @(negedge sclk); #1;
    cs_n = 1'b1;
    din  = 1'b0;
    #1;
    idle_check();
    repeat (2) @(negedge sclk);
    #1;
    idle_check();
  endtask

  initial begin
    #10;
    idle_check();
    rst_n = 1'b1;
    #5;
    txn(0, 1'b1, 1'b0, 1'b1, 1'b1, 12'hA5C, 30);
    txn(3, 1'b0, 1'b1, 1'b0, 1'b1, 12'h3E1, 32);
    txn(1, 1'b1, 1'b1, 1'b1, 1'b0, 12'h000, 22);
    txn(0, 1'b0, 1'b0, 1'b1, 1'b1, 12'hFFF, 20);
    txn(0, 1'b0, 1'b1, 1'b1, 1'b1, 12'h5A5, 10);
    $display("R10 abort done, restarting");
    txn(2, 1'b0, 1'b0, 1'b0, 1'b1, 12'h801, 31);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule